// File: doc/BRIEF.md
# Capture/Reload Timer with Baud Strobe

This block is a 16-bit up-counter with a small register file, meant to sit beside a processor core as a general-purpose timer. The count advances either on a fixed divided-down tick of the block clock or on falling edges seen on an external count pin. A second external pin, the trigger pin, can either copy the running count into a 16-bit capture/reload register or force the count back to the value held there. Which of these it does depends on the selected mode.

Software picks one of three modes through control bits. In capture mode the count wraps to zero. In auto-reload mode a rollover reloads the count from the capture/reload register. Baud mode is used as a bit-clock source for a serial port. It also reloads on rollover, but it raises no overflow flag, ignores the trigger pin, and emits a one-cycle strobe on every rollover. Two sticky flags record overflow and trigger events. Hardware sets them, software clears them, and their OR is the interrupt request.

Top module: `cr_timer`

## Requirements
- R1: After reset every register reads 0x00, and `irq` and `baud_tick` are low. The register map is: address 0 control, 1 count low byte, 2 count high byte, 3 capture/reload low byte, 4 capture/reload high byte. Any other address reads 0x00.
- R2: The control byte bits are: bit 7 overflow flag, bit 6 trigger flag, bit 5 receive baud select, bit 4 transmit baud select, bit 3 trigger enable, bit 2 run, bit 1 source select, bit 0 capture select. When run is 1 and source select is 0, the count increments once every PRESCALE clock cycles (default 12).
- R3: When run is 1 and source select is 1, the count increments exactly once per falling edge on `cnt_pin`. When run is 0, the count does not change.
- R4: Capture mode is selected when both baud selects are 0 and capture select is 1. In this mode, with trigger enable 1, a falling edge on `trig_pin` copies the count into the capture/reload register and sets the trigger flag.
- R5: With trigger enable 0, a falling edge on `trig_pin` changes neither the registers nor the trigger flag.
- R6: Auto-reload mode is selected when both baud selects are 0 and capture select is 0. In this mode a rollover from 0xFFFF loads the count from the capture/reload register and sets the overflow flag.
- R7: In auto-reload mode, with trigger enable 1, a falling edge on `trig_pin` loads the count from the capture/reload register and sets the trigger flag.
- R8: In capture mode a rollover wraps the count to 0x0000 and sets the overflow flag.
- R9: Baud mode is selected when either baud select is 1, whatever capture select holds. In this mode a rollover reloads the count, leaves the overflow flag unchanged, and pulses `baud_tick` high for exactly one cycle.
- R10: In baud mode a falling edge on `trig_pin` causes no capture, no reload and no trigger flag, even with trigger enable 1.
- R11: Writing 1 to a flag bit never sets it, and writing 0 clears it. A hardware set in the same cycle as a clear wins.
- R12: `irq` is high exactly when at least one of the two flags is set.
- R13: A software write to a count byte in the same cycle as a hardware increment or reload wins. The written byte takes the write data, and the other byte keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register (combinational) |
| cnt_pin | input | 1 | External count source, active on falling edge |
| trig_pin | input | 1 | External capture/reload trigger, active on falling edge |
| irq | output | 1 | Interrupt request, OR of the two flags |
| baud_tick | output | 1 | One-cycle strobe per rollover in baud mode |

## Verification
The properties assume that both pins idle high through reset. They also assume that every low or high level on a pin lasts at least two clock cycles, so that each falling edge passes the synchronizer once and two rollovers can never occur on adjacent cycles. The bench keeps its pulses three cycles wide and holds both pins high outside directed pulses. The randomised runs use the prescaled tick source, so one rollover is at least PRESCALE cycles from the next. The random values cover start counts, reload values, tick counts and modes. Start counts are drawn close to 0xFFFF so that rollovers occur often.

// File: rtl/cr_timer_pkg.sv
package cr_timer_pkg;

    localparam int BYTE_W    = 8;
    localparam int CNT_BYTES = 2;
    localparam int CNT_W     = BYTE_W * CNT_BYTES;
    localparam int ADDR_W    = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd2;
    localparam logic [ADDR_W-1:0] A_RLD_LO = 3'd3;
    localparam logic [ADDR_W-1:0] A_RLD_HI = 3'd4;

    typedef enum logic [1:0] {
        MD_RELOAD  = 2'd0,
        MD_CAPTURE = 2'd1,
        MD_BAUD    = 2'd2
    } tmode_e;

    typedef struct packed {
        logic ovf;
        logic ext;
        logic rx_sel;
        logic tx_sel;
        logic ext_en;
        logic run;
        logic cnt_sel;
        logic cap_sel;
    } ctrl_t;

    function automatic tmode_e mode_of(input ctrl_t c);
        if (c.rx_sel || c.tx_sel) return MD_BAUD;
        if (c.cap_sel)            return MD_CAPTURE;
        return MD_RELOAD;
    endfunction

    function automatic logic [BYTE_W-1:0] byte_of(input logic [CNT_W-1:0] v,
                                                 input int idx);
        return v[idx*BYTE_W +: BYTE_W];
    endfunction

endpackage

// File: rtl/crt_edge_fall.sv
module crt_edge_fall #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic fall_o
);
    // sh[0..STAGES-1] synchronise, sh[STAGES] holds the previous sample
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-1:0], pin_i};
    end

    assign fall_o = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/crt_prescaler.sv
module crt_prescaler #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick_o
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en)      cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    assign tick_o = en && (cnt == LAST);
endmodule

// File: rtl/crt_core.sv
module crt_core
    import cr_timer_pkg::*;
#(
    parameter int NB = CNT_BYTES
) (
    input  logic                  clk,
    input  logic                  rst,
    input  tmode_e                mode,
    input  logic                  inc,
    input  logic                  trig_ev,
    input  logic [NB-1:0]         wr_cnt_b,
    input  logic [NB-1:0]         wr_rld_b,
    input  logic [BYTE_W-1:0]     wdata,
    output logic [NB*BYTE_W-1:0]  count_o,
    output logic [NB*BYTE_W-1:0]  rld_o,
    output logic                  roll_o
);
    localparam int W = NB * BYTE_W;

    logic [W-1:0] count_q, count_d;
    logic [W-1:0] rld_q, rld_d;
    logic         do_load;
    logic         do_capture;

    assign roll_o     = inc && (&count_q);
    assign do_load    = (roll_o && mode != MD_CAPTURE) ||
                        (trig_ev && mode == MD_RELOAD);
    assign do_capture = trig_ev && (mode == MD_CAPTURE);

    always_comb begin
        count_d = count_q;
        if (|wr_cnt_b) begin
            for (int b = 0; b < NB; b++)
                if (wr_cnt_b[b]) count_d[b*BYTE_W +: BYTE_W] = wdata;
        end else if (do_load) begin
            count_d = rld_q;
        end else if (inc) begin
            count_d = count_q + W'(1);
        end
    end

    always_comb begin
        rld_d = rld_q;
        for (int b = 0; b < NB; b++) begin
            if (wr_rld_b[b])
                rld_d[b*BYTE_W +: BYTE_W] = wdata;
            else if (do_capture)
                rld_d[b*BYTE_W +: BYTE_W] = count_q[b*BYTE_W +: BYTE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            rld_q   <= '0;
        end else begin
            count_q <= count_d;
            rld_q   <= rld_d;
        end
    end

    assign count_o = count_q;
    assign rld_o   = rld_q;
endmodule

// File: rtl/cr_timer.sv
module cr_timer
    import cr_timer_pkg::*;
#(
    parameter int PRESCALE    = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              cnt_pin,
    input  logic              trig_pin,
    output logic              irq,
    output logic              baud_tick
);
    ctrl_t               ctrl_q, ctrl_d, wv;
    tmode_e              mode;
    logic                cnt_fall, trig_fall, tick;
    logic                inc, trig_ev, roll;
    logic                ctrl_wr, cnt_wr, rld_wr;
    logic [CNT_BYTES-1:0] wr_cnt_b, wr_rld_b;
    logic [CNT_W-1:0]    count_q, rld_q;
    logic                baud_q;

    assign mode = mode_of(ctrl_q);

    crt_edge_fall #(.STAGES(SYNC_STAGES)) u_cnt_edge (
        .clk(clk), .rst(rst), .pin_i(cnt_pin), .fall_o(cnt_fall));

    crt_edge_fall #(.STAGES(SYNC_STAGES)) u_trig_edge (
        .clk(clk), .rst(rst), .pin_i(trig_pin), .fall_o(trig_fall));

    crt_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk(clk), .rst(rst), .en(ctrl_q.run && !ctrl_q.cnt_sel), .tick_o(tick));

    assign inc     = ctrl_q.run && (ctrl_q.cnt_sel ? cnt_fall : tick);
    assign trig_ev = trig_fall && ctrl_q.ext_en && (mode != MD_BAUD);

    assign ctrl_wr     = reg_wr && (reg_addr == A_CTRL);
    assign wr_cnt_b[0] = reg_wr && (reg_addr == A_CNT_LO);
    assign wr_cnt_b[1] = reg_wr && (reg_addr == A_CNT_HI);
    assign wr_rld_b[0] = reg_wr && (reg_addr == A_RLD_LO);
    assign wr_rld_b[1] = reg_wr && (reg_addr == A_RLD_HI);
    assign cnt_wr      = |wr_cnt_b;
    assign rld_wr      = |wr_rld_b;

    crt_core #(.NB(CNT_BYTES)) u_core (
        .clk(clk), .rst(rst), .mode(mode), .inc(inc), .trig_ev(trig_ev),
        .wr_cnt_b(wr_cnt_b), .wr_rld_b(wr_rld_b), .wdata(reg_wdata),
        .count_o(count_q), .rld_o(rld_q), .roll_o(roll));

    assign wv = ctrl_t'(reg_wdata);

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_wr) begin
            ctrl_d     = wv;
            ctrl_d.ovf = ctrl_q.ovf & wv.ovf;
            ctrl_d.ext = ctrl_q.ext & wv.ext;
        end
        if (roll && mode != MD_BAUD) ctrl_d.ovf = 1'b1;
        if (trig_ev)                 ctrl_d.ext = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            baud_q <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
            baud_q <= roll && (mode == MD_BAUD);
        end
    end

    always_comb begin
        case (reg_addr)
            A_CTRL:   reg_rdata = ctrl_q;
            A_CNT_LO: reg_rdata = byte_of(count_q, 0);
            A_CNT_HI: reg_rdata = byte_of(count_q, 1);
            A_RLD_LO: reg_rdata = byte_of(rld_q, 0);
            A_RLD_HI: reg_rdata = byte_of(rld_q, 1);
            default:  reg_rdata = '0;
        endcase
    end

    assign irq       = ctrl_q.ovf | ctrl_q.ext;
    assign baud_tick = baud_q;
endmodule

// File: rtl/cr_timer_chk.sv
module cr_timer_chk (
    input logic        clk,
    input logic        rst,
    input logic [7:0]  ctrl_q,
    input logic [15:0] count_q,
    input logic [15:0] rld_q,
    input logic        roll,
    input logic        trig_ev,
    input logic        ctrl_wr,
    input logic        cnt_wr,
    input logic        rld_wr,
    input logic        irq,
    input logic        baud_tick
);
    logic baud_md;
    assign baud_md = ctrl_q[5] | ctrl_q[4];

    p_irq_cause_r12: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(roll || trig_ev));

    p_baud_single_r9: assert property (@(posedge clk) disable iff (rst)
        baud_tick |=> !baud_tick);

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        (baud_md && !ctrl_q[7]) |=> !ctrl_q[7]);

    p_reload_roll_r6: assert property (@(posedge clk) disable iff (rst)
        (roll && !baud_md && !ctrl_q[0] && !cnt_wr) |=> (count_q == $past(rld_q)));

    p_capture_r4: assert property (@(posedge clk) disable iff (rst)
        (trig_ev && !baud_md && ctrl_q[0] && !rld_wr) |=> (rld_q == $past(count_q)));

    p_flag_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[7] && !ctrl_wr) |=> ctrl_q[7]);

    p_ext_gate_r5: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q[3] && !ctrl_q[6] && !ctrl_wr) |=> !ctrl_q[6]);
endmodule

bind cr_timer cr_timer_chk u_chk (
    .clk(clk), .rst(rst), .ctrl_q(ctrl_q), .count_q(count_q), .rld_q(rld_q),
    .roll(roll), .trig_ev(trig_ev), .ctrl_wr(ctrl_wr), .cnt_wr(cnt_wr),
    .rld_wr(rld_wr), .irq(irq), .baud_tick(baud_tick));

// File: tb/cr_timer_bench.sv
module cr_timer_bench;
    localparam int PRE = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       cnt_pin = 1'b1;
    logic       trig_pin = 1'b1;
    logic       irq, baud_tick;

    int checks = 0, errors = 0, strobes = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cr_timer #(.PRESCALE(PRE)) u_cr_timer (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_pin(cnt_pin),
        .trig_pin(trig_pin), .irq(irq), .baud_tick(baud_tick));

    always @(negedge clk) if (baud_tick) strobes++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd16(input logic [2:0] a, output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(a, lo); rd(a + 3'd1, hi);
        v = {hi, lo};
    endtask

    task automatic set16(input logic [2:0] a, input logic [15:0] v);
        wr(a, v[7:0]); wr(a + 3'd1, v[15:8]);
    endtask

    task automatic pulse(input bit on_cnt);
        @(negedge clk);
        if (on_cnt) cnt_pin = 1'b0; else trig_pin = 1'b0;
        repeat (3) @(negedge clk);
        cnt_pin = 1'b1; trig_pin = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // md: 0 reload, 1 capture, 2 baud
    function automatic void model(input logic [15:0] s, input logic [15:0] r,
                                  input int k, input int md,
                                  output logic [15:0] c, output int rolls);
        c = s; rolls = 0;
        for (int i = 0; i < k; i++) begin
            if (c == 16'hFFFF) begin
                rolls++;
                c = (md == 1) ? 16'h0000 : r;
            end else c = c + 16'd1;
        end
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] v, exp_c;
        int rolls;
        void'($urandom(32'h5eed_c0de));
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(a[2:0], b);
            check("R1 reg", b, 8'h00);
        end
        check("R1 irq", irq, 0);
        check("R1 baud_tick", baud_tick, 0);

        // R2 prescaled tick: 5 ticks
        wr(3'd0, 8'h04);
        repeat (5*PRE) @(posedge clk);
        rd16(3'd1, v);
        check("R2 tick count", v, 16'd5);
        wr(3'd0, 8'h00);

        // R3 event counting
        set16(3'd1, 16'h0010);
        wr(3'd0, 8'h06);
        for (int i = 0; i < 5; i++) pulse(1);
        rd16(3'd1, v);
        check("R3 event count", v, 16'h0015);
        wr(3'd0, 8'h02);
        for (int i = 0; i < 3; i++) pulse(1);
        rd16(3'd1, v);
        check("R3 run clear holds", v, 16'h0015);

        // R5 trigger ignored without enable (capture mode)
        set16(3'd1, 16'hABCD);
        wr(3'd0, 8'h01);
        pulse(0);
        rd16(3'd3, v);
        check("R5 no capture", v, 16'h0000);
        rd(3'd0, b);
        check("R5 no flag", b[6], 0);

        // R4 capture
        wr(3'd0, 8'h09);
        pulse(0);
        rd16(3'd3, v);
        check("R4 captured", v, 16'hABCD);
        rd(3'd0, b);
        check("R4 trig flag", b[6], 1);
        check("R12 irq from trig flag", irq, 1);

        // R11 writing 1 keeps, writing 0 clears
        wr(3'd0, 8'h40);
        rd(3'd0, b);
        check("R11 write one keeps", b, 8'h40);
        wr(3'd0, 8'h00);
        rd(3'd0, b);
        check("R11 clear", b, 8'h00);
        check("R12 irq low", irq, 0);
        wr(3'd0, 8'hC0);
        rd(3'd0, b);
        check("R11 write one no set", b, 8'h00);

        // R7 reload by trigger
        set16(3'd3, 16'h1234);
        set16(3'd1, 16'h0777);
        wr(3'd0, 8'h08);
        pulse(0);
        rd16(3'd1, v);
        check("R7 trig reload", v, 16'h1234);
        rd(3'd0, b);
        check("R7 trig flag", b[6], 1);

        // R10 baud mode ignores trigger
        wr(3'd0, 8'h18);
        set16(3'd1, 16'h0777);
        pulse(0);
        rd16(3'd1, v);
        check("R10 no reload", v, 16'h0777);
        rd(3'd0, b);
        check("R10 no flag", b[6], 0);
        wr(3'd0, 8'h29);
        pulse(0);
        rd16(3'd3, v);
        check("R10 no capture", v, 16'h1234);

        // R13 software write wins over increment
        wr(3'd0, 8'h00);
        set16(3'd1, 16'h00FF);
        wr(3'd0, 8'h04);
        repeat (PRE-1) @(posedge clk);
        wr(3'd1, 8'h55);
        wr(3'd0, 8'h00);
        rd16(3'd1, v);
        check("R13 write wins", v, 16'h0055);

        // Randomised mode runs: R6 reload, R8 capture, R9 baud
        for (int it = 0; it < 12; it++) begin
            logic [15:0] s, r;
            int k, md;
            logic [7:0] cv;
            string tag;
            s  = 16'hFFFF - 16'($urandom_range(0, 20));
            r  = 16'hFFE0 + 16'($urandom_range(0, 31));
            k  = $urandom_range(1, 40);
            md = it % 3;
            case (md)
                0: begin cv = 8'h04; tag = "R6"; end
                1: begin cv = 8'h05; tag = "R8"; end
                default: begin
                    cv = ($urandom_range(0, 1) != 0) ? 8'h25 : 8'h14;
                    tag = "R9";
                end
            endcase
            wr(3'd0, 8'h00);
            set16(3'd1, s);
            set16(3'd3, r);
            repeat (2) @(negedge clk);
            strobes = 0;
            wr(3'd0, cv);
            repeat (k*PRE - 1) @(posedge clk);
            @(negedge clk);
            model(s, r, k, md, exp_c, rolls);
            rd16(3'd1, v);
            check({tag, " count"}, v, exp_c);
            rd(3'd0, b);
            check({tag, " overflow flag"}, b[7], (md != 2 && rolls > 0));
            check("R12 irq", irq, (md != 2 && rolls > 0));
            wr(3'd0, 8'h00);
            repeat (2) @(negedge clk);
            check({tag, " strobes"}, strobes, (md == 2) ? rolls : 0);
        end

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule